// File: doc/BRIEF.md
# SPI Serial-Clock Divider with Selectable Ratio

This block makes the serial clock for an SPI master. A free-running binary counter, clocked on the falling edge of the system clock, gives one tap per power of two. A small selector then drives one of those taps onto the serial-clock output. The host bus writes a control word, and the low bits of that word hold the divide select. None of the four settings passes the system clock straight through, so the fastest serial clock is half the system clock.

The counter has no reset or clear path. Changing the select therefore never restarts the count. The output moves to the new tap in the same cycle, so the first high or low phase after a change may be short, and that is allowed. For the shift logic downstream, the block also gives a registered pulse, one system clock wide. It appears in the cycle after each rising edge of the selected serial clock.

Top module: `spi_sclk_divsel`

## Requirements
- R1: Select 00 gives a serial-clock period of 2 system clocks, 01 gives 4, 10 gives 8 and 11 gives 16, once the select has settled.
- R2: The select is taken from bits [1:0] of the written control word. Bits above bit 1 have no effect on the serial clock.
- R3: The control register loads on a rising system-clock edge while `wr_en` is high. While `wr_en` is low it holds its value, whatever is on `wr_data`.
- R4: Synchronous reset clears the select to 00, so after reset the serial clock runs at half the system clock.
- R5: The divider counter runs freely and advances by one every system-clock cycle. A change of select does not restart it, so a ratio that is chosen again keeps its earlier rising-edge phase.
- R6: The counter advances on the falling system-clock edge. The serial clock therefore changes only at falling edges and stays steady from each rising edge until the next falling edge.
- R7: A new select reaches the serial clock in the cycle it is loaded. There is no glitch-free handover, and the first phase after a change may be short.
- R8: In steady state the serial clock has a 50% duty cycle. The high and low phases each last 1, 2, 4 or 8 system clocks for selects 00 to 11.
- R9: `sclk_rise_o` is high for exactly one system clock, starting at the rising system-clock edge that follows each low-to-high change of `sclk_o`. It is low at all other times.
- R10: While reset is held, `sclk_rise_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high, for the control register and the edge pulse |
| wr_en | input | 1 | Host write strobe for the control register |
| wr_data | input | CTRL_W (8) | Host write data; bits [1:0] hold the divide select |
| sclk_o | output | 1 | Selected divided serial clock |
| sclk_rise_o | output | 1 | One-cycle pulse after each rising edge of `sclk_o` |

## Verification
A corrupted counter shows up at `sclk_o` within one half-period of the chosen ratio: a high or low phase comes out with the wrong length, or a rising edge lands off the phase grid that the same select had before. A wrong select register changes the measured period from the first full phase after the write. A broken edge detector is caught at the next rising edge of `sclk_o`: the pulse is missing, it is two cycles wide, or it is a cycle late. Each measurement uses only rising edges that occur after the write has taken effect. This keeps the allowed short phase after a change out of the period checks.

// File: rtl/spi_div_pkg.sv
`timescale 1ns/1ps
package spi_div_pkg;
   // Width of a select that indexes n taps; at least one bit.
   function automatic int unsigned sel_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   localparam int unsigned MAX_TAPS = 16;
endpackage

// File: rtl/spi_div_ctl_reg.sv
`timescale 1ns/1ps
module spi_div_ctl_reg #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   output logic [SEL_W-1:0] sel_q
);
   always_ff @(posedge clk) begin
      if (rst)        sel_q <= '0;
      else if (wr_en) sel_q <= wr_sel;
   end

   // R3
   sel_load_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> sel_q == $past(wr_sel));
   // R3
   sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(sel_q));
   // R4
   sel_reset_chk: assert property (@(posedge clk)
      rst |=> sel_q == '0);
endmodule

// File: rtl/spi_div_ripple.sv
`timescale 1ns/1ps
module spi_div_ripple #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,   // feeds only the checks; the count has no clear
   output logic [WIDTH-1:0] taps_o
);
   // Zero start exists for simulation only; hardware powers up anywhere.
   logic [WIDTH-1:0] cnt_q = '0;

   always_ff @(negedge clk) begin
      cnt_q <= cnt_q + 1'b1;
   end

   assign taps_o = cnt_q;

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q == WIDTH'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/spi_div_mux.sv
`timescale 1ns/1ps
module spi_div_mux #(
   parameter int unsigned NUM_TAPS = 4,
   parameter int unsigned SEL_W    = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_TAPS-1:0] taps_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic                tap_o
);
   localparam int unsigned SLOTS = 1 << SEL_W;

   logic [SLOTS-1:0] padded;

   // Unused select codes repeat the slowest tap.
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_TAPS) begin : g_real
         assign padded[i] = taps_i[i];
      end else begin : g_fill
         assign padded[i] = taps_i[NUM_TAPS-1];
      end
   end

   assign tap_o = padded[sel_i];

   // R1
   fast_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_i == '0 && $past(sel_i) == '0) |-> tap_o != $past(tap_o));
endmodule

// File: rtl/spi_div_edge.sv
`timescale 1ns/1ps
module spi_div_edge (
   input  logic clk,
   input  logic rst,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;
   logic rise_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         rise_q <= lvl_i & ~prev_q;
      end
   end

   assign rise_o = rise_q;

   // R9
   rise_single_chk: assert property (@(posedge clk) disable iff (rst)
      rise_q |=> !rise_q);
   // R9
   rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rise_q |-> ($past(lvl_i) && !$past(lvl_i, 2)));
   // R10
   rise_reset_chk: assert property (@(posedge clk)
      rst |=> !rise_q);
endmodule

// File: rtl/spi_sclk_divsel.sv
`timescale 1ns/1ps
module spi_sclk_divsel #(
   parameter int unsigned NUM_TAPS = 4,
   parameter int unsigned CTRL_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic              sclk_o,
   output logic              sclk_rise_o
);
   localparam int unsigned SEL_W = spi_div_pkg::sel_bits(NUM_TAPS);

   if (NUM_TAPS < 1 || NUM_TAPS > spi_div_pkg::MAX_TAPS) begin : g_bad_taps
      $error("spi_sclk_divsel: NUM_TAPS out of range");
   end
   if (CTRL_W < SEL_W) begin : g_bad_ctrl
      $error("spi_sclk_divsel: CTRL_W narrower than select field");
   end

   logic [SEL_W-1:0]    sel;
   logic [NUM_TAPS-1:0] taps;
   logic                sclk;

   if (CTRL_W > SEL_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[CTRL_W-1:SEL_W];
   end

   spi_div_ctl_reg #(.SEL_W(SEL_W)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_sel (wr_data[SEL_W-1:0]),
      .sel_q  (sel)
   );

   spi_div_ripple #(.WIDTH(NUM_TAPS)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .taps_o (taps)
   );

   spi_div_mux #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_mux (
      .clk    (clk),
      .rst    (rst),
      .taps_i (taps),
      .sel_i  (sel),
      .tap_o  (sclk)
   );

   spi_div_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (sclk),
      .rise_o (sclk_rise_o)
   );

   assign sclk_o = sclk;
endmodule

// File: tb/sim_spi_sclk_divsel.sv
`timescale 1ns/1ps
module sim_spi_sclk_divsel;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       sclk_o;
   logic       sclk_rise_o;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int done_n = 0;
   int pushed = 0;
   int last_rise [4] = '{-1, -1, -1, -1};

   typedef struct {
      int    sel;
      string req;
   } exp_t;
   exp_t exp_q [$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_sclk_divsel u0 (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .sclk_o      (sclk_o),
      .sclk_rise_o (sclk_rise_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic smp(output logic v);
      @(posedge clk);
      #1;
      v = sclk_o;
   endtask

   task automatic wr(input logic [7:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   // Driver side: queue an expected ratio and wait for the monitor.
   task automatic push(input int s, input string req);
      exp_t it;
      it.sel = s; it.req = req;
      exp_q.push_back(it);
      pushed++;
      wait (done_n == pushed);
   endtask

   // Monitor: measures one steady-state period per queued item.
   task automatic measure(input exp_t it);
      int   half = 1 << it.sel;
      int   h, l, g, rc;
      logic prev, cur;
      smp(cur);
      g = 0;
      do begin prev = cur; smp(cur); g++; end while (!(!prev && cur) && g < 200);
      // skip one whole period so any short phase is gone
      g = 0;
      do begin prev = cur; smp(cur); g++; end while (!(!prev && cur) && g < 200);
      rc = cyc;
      chk(sclk_rise_o == 1'b1, {it.req, "/R9 pulse at rise"}, sclk_rise_o, 1);
      #3;
      chk(sclk_o == cur, {it.req, "/R6 steady before fall"}, sclk_o, cur);
      if (last_rise[it.sel] >= 0)
         chk(((rc - last_rise[it.sel]) % (2 * half)) == 0, {it.req, "/R5 phase kept"},
             (rc - last_rise[it.sel]) % (2 * half), 0);
      last_rise[it.sel] = rc;
      h = 1;
      smp(cur);
      chk(sclk_rise_o == 1'b0, {it.req, "/R9 pulse one cycle"}, sclk_rise_o, 0);
      while (cur && h < 64) begin h++; smp(cur); end
      l = 1;
      smp(cur);
      while (!cur && l < 64) begin l++; smp(cur); end
      chk(h == half, {it.req, "/R1 high phase"}, h, half);
      chk(l == half, {it.req, "/R8 low phase"}, l, half);
      chk(sclk_rise_o == 1'b1, {it.req, "/R9 next pulse"}, sclk_rise_o, 1);
   endtask

   initial begin : monitor
      forever begin
         exp_t it;
         wait (exp_q.size() > 0);
         it = exp_q.pop_front();
         measure(it);
         done_n++;
      end
   end

   initial begin : watchdog
      #(50000 * 10);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : driver
      logic a, b, c;
      repeat (3) @(posedge clk);
      #1;
      chk(sclk_rise_o == 1'b0, "R10 pulse low in reset", sclk_rise_o, 0);
      @(posedge clk); #2;
      rst = 1'b0;
      push(0, "R4");
      wr(8'h01); push(1, "R1");
      wr(8'h02); push(2, "R1");
      wr(8'h03); push(3, "R1");
      wr(8'hFE); push(2, "R2");          // upper bits ignored, sel=10
      // wr_en low: data on the bus must not load
      @(posedge clk); #2; wr_data = 8'h03;
      repeat (5) @(posedge clk);
      #2; wr_data = 8'h00;
      push(2, "R3");
      wr(8'h03); push(3, "R5");
      // immediate switch to /2: output toggles each cycle right after the load
      @(posedge clk); #2; wr_en = 1'b1; wr_data = 8'h00;
      @(posedge clk); #1; a = sclk_o; #1; wr_en = 1'b0;
      @(posedge clk); #1; b = sclk_o;
      @(posedge clk); #1; c = sclk_o;
      chk(a != b, "R7 first toggle", b, !a);
      chk(b != c, "R7 second toggle", c, !b);
      wr(8'h5D); push(1, "R2");          // 0101_1101 -> sel=01
      // reset mid-run returns to /2
      @(posedge clk); #2; rst = 1'b1;
      @(posedge clk); #1;
      chk(sclk_rise_o == 1'b0, "R10 pulse low in reset", sclk_rise_o, 0);
      @(posedge clk); #2; rst = 1'b0;
      push(0, "R4");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule